// File: doc/BRIEF.md
# Weighted Rectangle Feature Sum Collector

This block turns integral-image corner samples into weighted feature sums for a cascade classifier. Each rectangle of a feature has its own collection lane. A lane takes the four corner values of its rectangle one per cycle, in a strict order: top-left, top-right, bottom-left, bottom-right. When the last corner arrives, the lane forms the rectangle's area sum. Because corner data always moves in one direction, the lanes work side by side, and their rectangles may finish in any order or in the same cycle.

A feature uses the first `num_rects` lanes. Each finished rectangle sum is multiplied by that lane's signed weight and added to the feature total. The total is presented to the downstream evaluation stage, with a one-cycle strobe, only once every required lane has finished. The following faults drop the partial feature and raise an error strobe instead:

- a corner that arrives out of order;
- a strobe that goes missing partway through a rectangle;
- a lane that finishes twice within one feature.

Top module: `rsc_feature_collector`

## Requirements
- R1: After reset, `feat_valid` and `feat_err` are low and `feat_sum` is zero.
- R2: Corner codes on `corner_idx` are 0 = top-left, 1 = top-right, 2 = bottom-left, 3 = bottom-right. A lane's rectangle sum is BR − TR − BL + TL, computed in signed arithmetic on unsigned corner values.
- R3: The four corners of one rectangle must arrive on consecutive cycles. If the strobe is low after the first corner and before the last, the lane's partial data is dropped and the feature fails.
- R4: A corner whose code differs from the one the lane expects next is discarded, the lane restarts at top-left, and the feature fails.
- R5: The feature sum is Σ weight_i × rect_i over lanes i < `num_rects`. Weight i is a signed two's-complement field at `rect_weight[i*WT_W +: WT_W]`.
- R6: `feat_valid` pulses for exactly one cycle, only after every required lane has finished. It is high in the cycle after the clock edge that follows the edge sampling the last bottom-right corner.
- R7: Rectangles finished by lanes at index ≥ `num_rects` have no effect on the feature sum or on the strobes.
- R8: A fault on a required lane pulses `feat_err` one cycle after the lane detects it. The fault clears all accumulated feature state, so the next feature starts from zero. `feat_valid` and `feat_err` are never high together.
- R9: A required lane that finishes a second time before its feature completes pulses `feat_err` and clears the feature state.
- R10: Lanes run concurrently. Required lanes may finish in any order, including in the same cycle.
- R11: Full-scale corner values (0 and 2^II_W − 1) give exact results with no overflow, for both negative and positive rectangle sums.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| corner_valid | input | LANES | Corner strobe, one per lane |
| corner_idx | input | 2*LANES | Corner code per lane |
| corner_val | input | II_W*LANES | Integral-image corner value per lane (unsigned) |
| rect_weight | input | WT_W*LANES | Signed weight per lane |
| num_rects | input | CNT_W | Number of lanes the current feature uses |
| feat_valid | output | 1 | One-cycle strobe for a completed feature |
| feat_sum | output | FS_W | Signed weighted feature sum |
| feat_err | output | 1 | One-cycle strobe for a dropped feature |

## Verification
The bench drives sequences that separate the arithmetic from the sequencing:

- **Strictly sequential completions.** One lane finishes alone; the bench shows the output stays quiet, then a second lane finishes. This separates "wait for all lanes" from "emit on any lane".
- **Simultaneous and staggered completions with full-scale corners.** These expose sign, headroom and summing-order errors.
- **Traffic on an unused lane.** Its large weight makes any leakage into the sum visible.
- **Fault cases.** A swapped corner, a broken strobe and a duplicate completion are each followed by a clean feature. The bench checks that the stale partial sum is gone, which separates "flag and drop" from "flag only".

// File: rtl/rsc_pkg.sv
package rsc_pkg;

    // Corner arrival order; the lane walks this sequence and wraps.
    typedef enum logic [1:0] {
        CORNER_TL = 2'd0,
        CORNER_TR = 2'd1,
        CORNER_BL = 2'd2,
        CORNER_BR = 2'd3
    } corner_e;

    function automatic int sum_width(input int ii_w, input int wt_w, input int lanes);
        return ii_w + 2 + wt_w + $clog2(lanes) + 1;
    endfunction

endpackage

// File: rtl/rsc_corner_lane.sv
module rsc_corner_lane
    import rsc_pkg::*;
#(
    parameter int II_W = 16,
    localparam int RS_W = II_W + 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [1:0]             in_idx,
    input  logic [II_W-1:0]        in_val,
    output logic                   out_done,
    output logic                   out_err,
    output logic signed [RS_W-1:0] out_sum
);

    typedef struct packed {
        corner_e                nxt;
        logic [II_W-1:0]        tl;
        logic [II_W-1:0]        tr;
        logic [II_W-1:0]        bl;
        logic signed [RS_W-1:0] sum;
        logic                   done;
        logic                   err;
    } lane_st_t;

    lane_st_t st_d, st_q;
    logic signed [RS_W-1:0] rect_d;

    always_comb begin
        rect_d = $signed({2'b00, in_val}) - $signed({2'b00, st_q.tr})
               - $signed({2'b00, st_q.bl}) + $signed({2'b00, st_q.tl});

        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.err  = 1'b0;

        if (in_valid) begin
            if (corner_e'(in_idx) == st_q.nxt) begin
                unique case (st_q.nxt)
                    CORNER_TL: begin st_d.tl = in_val; st_d.nxt = CORNER_TR; end
                    CORNER_TR: begin st_d.tr = in_val; st_d.nxt = CORNER_BL; end
                    CORNER_BL: begin st_d.bl = in_val; st_d.nxt = CORNER_BR; end
                    CORNER_BR: begin
                        st_d.sum  = rect_d;
                        st_d.done = 1'b1;
                        st_d.nxt  = CORNER_TL;
                    end
                    default: st_d.nxt = CORNER_TL;
                endcase
            end else begin
                // Out-of-order corner: drop everything gathered so far.
                st_d.err = 1'b1;
                st_d.nxt = CORNER_TL;
            end
        end else if (st_q.nxt != CORNER_TL) begin
            // Strobe vanished in the middle of a rectangle.
            st_d.err = 1'b1;
            st_d.nxt = CORNER_TL;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_done = st_q.done;
    assign out_err  = st_q.err;
    assign out_sum  = st_q.sum;

endmodule

// File: rtl/rsc_weight_mul.sv
module rsc_weight_mul #(
    parameter int RS_W = 18,
    parameter int WT_W = 4,
    parameter int FS_W = 25,
    localparam int PR_W = RS_W + WT_W
) (
    input  logic signed [RS_W-1:0] rect,
    input  logic signed [WT_W-1:0] weight,
    output logic signed [FS_W-1:0] prod
);

    logic signed [PR_W-1:0] full;

    assign full = $signed({{WT_W{rect[RS_W-1]}}, rect}) *
                  $signed({{RS_W{weight[WT_W-1]}}, weight});
    assign prod = {{(FS_W-PR_W){full[PR_W-1]}}, full};

endmodule

// File: rtl/rsc_feature_acc.sv
module rsc_feature_acc #(
    parameter int LANES = 3,
    parameter int RS_W  = 18,
    parameter int WT_W  = 4,
    parameter int FS_W  = 25,
    localparam int CNT_W = $clog2(LANES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        lane_done,
    input  logic [LANES-1:0]        lane_err,
    input  logic [LANES*RS_W-1:0]   lane_sum,
    input  logic [LANES*WT_W-1:0]   rect_weight,
    input  logic [CNT_W-1:0]        num_rects,
    output logic                    feat_valid,
    output logic                    feat_err,
    output logic signed [FS_W-1:0]  feat_sum
);

    typedef struct packed {
        logic signed [FS_W-1:0] acc;
        logic signed [FS_W-1:0] out;
        logic [LANES-1:0]       seen;
        logic                   valid;
        logic                   err;
    } acc_st_t;

    acc_st_t st_d, st_q;

    logic [LANES-1:0]       req;
    logic signed [FS_W-1:0] prod [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign req[g] = (num_rects > CNT_W'(g));
        rsc_weight_mul #(.RS_W(RS_W), .WT_W(WT_W), .FS_W(FS_W)) u_mul (
            .rect   ($signed(lane_sum[g*RS_W +: RS_W])),
            .weight ($signed(rect_weight[g*WT_W +: WT_W])),
            .prod   (prod[g])
        );
    end

    logic [LANES-1:0]       fire;
    logic [LANES-1:0]       bad;
    logic [LANES-1:0]       seen_nx;
    logic signed [FS_W-1:0] acc_nx;

    always_comb begin
        fire    = lane_done & req;
        bad     = (lane_err & req) | (fire & st_q.seen);
        seen_nx = st_q.seen | fire;
        acc_nx  = st_q.acc;
        for (int i = 0; i < LANES; i++) begin
            if (fire[i]) acc_nx = acc_nx + prod[i];
        end

        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.err   = 1'b0;

        if (|bad) begin
            st_d.err  = 1'b1;
            st_d.acc  = '0;
            st_d.seen = '0;
        end else if ((|fire) && (seen_nx == req)) begin
            st_d.valid = 1'b1;
            st_d.out   = acc_nx;
            st_d.acc   = '0;
            st_d.seen  = '0;
        end else begin
            st_d.acc  = acc_nx;
            st_d.seen = seen_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign feat_valid = st_q.valid;
    assign feat_err   = st_q.err;
    assign feat_sum   = st_q.out;

endmodule

// File: rtl/rsc_feature_collector.sv
module rsc_feature_collector #(
    parameter int  LANES = 3,
    parameter int  II_W  = 16,
    parameter int  WT_W  = 4,
    localparam int CNT_W = $clog2(LANES + 1),
    localparam int FS_W  = rsc_pkg::sum_width(II_W, WT_W, LANES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LANES-1:0]       corner_valid,
    input  logic [2*LANES-1:0]     corner_idx,
    input  logic [II_W*LANES-1:0]  corner_val,
    input  logic [WT_W*LANES-1:0]  rect_weight,
    input  logic [CNT_W-1:0]       num_rects,
    output logic                   feat_valid,
    output logic [FS_W-1:0]        feat_sum,
    output logic                   feat_err
);

    localparam int RS_W = II_W + 2;

    logic [LANES-1:0]      lane_done;
    logic [LANES-1:0]      lane_err;
    logic [LANES*RS_W-1:0] lane_sum;

    for (genvar g = 0; g < LANES; g++) begin : g_col
        logic signed [RS_W-1:0] sum_w;
        rsc_corner_lane #(.II_W(II_W)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_valid (corner_valid[g]),
            .in_idx   (corner_idx[2*g +: 2]),
            .in_val   (corner_val[g*II_W +: II_W]),
            .out_done (lane_done[g]),
            .out_err  (lane_err[g]),
            .out_sum  (sum_w)
        );
        assign lane_sum[g*RS_W +: RS_W] = sum_w;
    end

    logic signed [FS_W-1:0] sum_s;

    rsc_feature_acc #(
        .LANES (LANES),
        .RS_W  (RS_W),
        .WT_W  (WT_W),
        .FS_W  (FS_W)
    ) u_acc (
        .clk         (clk),
        .rst_n       (rst_n),
        .lane_done   (lane_done),
        .lane_err    (lane_err),
        .lane_sum    (lane_sum),
        .rect_weight (rect_weight),
        .num_rects   (num_rects),
        .feat_valid  (feat_valid),
        .feat_err    (feat_err),
        .feat_sum    (sum_s)
    );

    assign feat_sum = sum_s;

endmodule

// File: rtl/rsc_checker.sv
module rsc_checker #(
    parameter int LANES = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [LANES-1:0]   corner_valid,
    input logic [2*LANES-1:0] corner_idx,
    input logic [LANES-1:0]   lane_done,
    input logic [LANES-1:0]   lane_err,
    input logic               feat_valid,
    input logic               feat_err
);

    // R8: a feature is either delivered or dropped, never both.
    p_valid_err_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(feat_valid && feat_err));

    // R6: the delivery strobe lasts one cycle.
    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        feat_valid |=> !feat_valid);

    // R6: delivery follows a lane completion in the previous cycle.
    p_valid_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        feat_valid |-> $past(|lane_done));

    // R9: an error strobe always has a lane event one cycle earlier.
    p_err_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        feat_err |-> $past((|lane_done) || (|lane_err)));

    for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
        // R2: a rectangle completes only after a sampled bottom-right corner.
        p_done_after_br_r2: assert property (@(posedge clk) disable iff (!rst_n)
            lane_done[g] |-> $past(corner_valid[g] && (corner_idx[2*g +: 2] == 2'd3)));
    end

endmodule

bind rsc_feature_collector rsc_checker #(.LANES(LANES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .corner_valid (corner_valid),
    .corner_idx   (corner_idx),
    .lane_done    (lane_done),
    .lane_err     (lane_err),
    .feat_valid   (feat_valid),
    .feat_err     (feat_err)
);

// File: tb/tb_rsc_feature_collector.sv
`timescale 1ns/1ps
module tb_rsc_feature_collector;

    localparam int LANES = 3;
    localparam int II_W  = 16;
    localparam int WT_W  = 4;
    localparam int CNT_W = $clog2(LANES + 1);
    localparam int FS_W  = II_W + 2 + WT_W + $clog2(LANES) + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [LANES-1:0]      cv = '0;
    logic [1:0]            cidx [LANES];
    logic [II_W-1:0]       cval [LANES];
    logic signed [WT_W-1:0] wt  [LANES];
    logic [CNT_W-1:0]      nrect = '0;

    logic [2*LANES-1:0]    corner_idx;
    logic [II_W*LANES-1:0] corner_val;
    logic [WT_W*LANES-1:0] rect_weight;
    logic                  feat_valid;
    logic [FS_W-1:0]       feat_sum;
    logic                  feat_err;

    for (genvar g = 0; g < LANES; g++) begin : g_pack
        assign corner_idx[2*g +: 2]        = cidx[g];
        assign corner_val[g*II_W +: II_W]  = cval[g];
        assign rect_weight[g*WT_W +: WT_W] = wt[g];
    end

    rsc_feature_collector #(.LANES(LANES), .II_W(II_W), .WT_W(WT_W)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .corner_valid (cv),
        .corner_idx   (corner_idx),
        .corner_val   (corner_val),
        .rect_weight  (rect_weight),
        .num_rects    (nrect),
        .feat_valid   (feat_valid),
        .feat_sum     (feat_sum),
        .feat_err     (feat_err)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit reported = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        end
    endtask

    function automatic longint rect_ref(input longint tl, input longint tr,
                                        input longint bl, input longint br);
        return br - tr - bl + tl;
    endfunction

    // Samples outputs one posedge later, away from the edge.
    task automatic expect_out(input string req, input bit v, input bit e, input longint s);
        @(posedge clk);
        #1;
        check(feat_valid == v, req, "feat_valid", longint'(feat_valid), longint'(v));
        check(feat_err == e, req, "feat_err", longint'(feat_err), longint'(e));
        if (v) check(longint'($signed(feat_sum)) == s, req, "feat_sum",
                     longint'($signed(feat_sum)), s);
    endtask

    task automatic put_corner(input int lane, input int idx, input int val);
        @(negedge clk);
        cv[lane]   = 1'b1;
        cidx[lane] = 2'(idx);
        cval[lane] = II_W'(val);
    endtask

    task automatic idle(input int lane);
        @(negedge clk);
        cv[lane] = 1'b0;
    endtask

    task automatic send_rect(input int lane, input int tl, input int tr,
                             input int bl, input int br);
        put_corner(lane, 0, tl);
        put_corner(lane, 1, tr);
        put_corner(lane, 2, bl);
        put_corner(lane, 3, br);
        idle(lane);
    endtask

    task automatic t_reset();
        #1;
        check(feat_valid == 1'b0, "R1", "feat_valid", longint'(feat_valid), 0);
        check(feat_err == 1'b0, "R1", "feat_err", longint'(feat_err), 0);
        check(feat_sum == '0, "R1", "feat_sum", longint'($signed(feat_sum)), 0);
    endtask

    task automatic t_two_rect();
        nrect = 2; wt[0] = -4'sd1; wt[1] = 4'sd2; wt[2] = 4'sd0;
        send_rect(0, 100, 300, 250, 900);
        expect_out("R6", 0, 0, 0);
        expect_out("R6", 0, 0, 0);
        send_rect(1, 10, 40, 30, 500);
        expect_out("R5", 1, 0, -rect_ref(100, 300, 250, 900) + 2 * rect_ref(10, 40, 30, 500));
        expect_out("R6", 0, 0, 0);
    endtask

    task automatic t_parallel_extreme();
        nrect = 3; wt[0] = 4'sd2; wt[1] = -4'sd1; wt[2] = 4'sd3;
        fork
            send_rect(0, 0, 65535, 65535, 0);
            send_rect(1, 65535, 0, 0, 65535);
            send_rect(2, 5, 7, 11, 60);
        join
        expect_out("R11", 1, 0, 2 * rect_ref(0, 65535, 65535, 0)
                              - rect_ref(65535, 0, 0, 65535)
                              + 3 * rect_ref(5, 7, 11, 60));
    endtask

    task automatic t_ignored_lane();
        nrect = 2; wt[0] = 4'sd3; wt[1] = 4'sd1; wt[2] = 4'sd7;
        send_rect(2, 0, 0, 0, 1000);
        expect_out("R7", 0, 0, 0);
        fork
            send_rect(0, 1, 2, 3, 20);
            begin idle(1); send_rect(1, 4, 4, 4, 9); end
        join
        expect_out("R10", 1, 0, 3 * rect_ref(1, 2, 3, 20) + rect_ref(4, 4, 4, 9));
    endtask

    task automatic t_out_of_order();
        nrect = 2; wt[0] = 4'sd1; wt[1] = 4'sd1;
        put_corner(0, 0, 5);
        put_corner(0, 2, 7);
        idle(0);
        expect_out("R4", 0, 1, 0);
        fork
            send_rect(0, 1, 1, 1, 9);
            send_rect(1, 0, 0, 0, 3);
        join
        expect_out("R4", 1, 0, 11);
    endtask

    task automatic t_gap();
        nrect = 2; wt[0] = 4'sd1; wt[1] = 4'sd1;
        send_rect(0, 0, 0, 0, 50);
        expect_out("R3", 0, 0, 0);
        put_corner(1, 0, 2);
        put_corner(1, 1, 3);
        idle(1);
        expect_out("R3", 0, 0, 0);
        expect_out("R3", 0, 1, 0);
        fork
            send_rect(0, 0, 0, 0, 7);
            send_rect(1, 0, 0, 0, 2);
        join
        expect_out("R8", 1, 0, 9);
    endtask

    task automatic t_duplicate();
        nrect = 2; wt[0] = 4'sd1; wt[1] = 4'sd1;
        send_rect(0, 0, 0, 0, 10);
        expect_out("R9", 0, 0, 0);
        send_rect(0, 0, 0, 0, 20);
        expect_out("R9", 0, 1, 0);
        send_rect(1, 0, 0, 0, 4);
        expect_out("R9", 0, 0, 0);
        send_rect(0, 0, 0, 0, 6);
        expect_out("R9", 1, 0, 10);
    endtask

    initial begin
        for (int i = 0; i < LANES; i++) begin
            cidx[i] = '0; cval[i] = '0; wt[i] = '0;
        end
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_two_rect();
        t_parallel_extreme();
        t_ignored_lane();
        t_out_of_order();
        t_gap();
        t_duplicate();
        repeat (3) @(posedge clk);
        report();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

endmodule